// File: doc/BRIEF.md
# Byte-Command SPI Master Engine

This engine turns a stream of command bytes into SPI bus activity. A host pushes bytes over a valid/ready input stream. Each command opens with an opcode. Some opcodes carry argument bytes after them. One kind sets the SCK rate, one sets the value and direction of an eight-bit pin bank, and one turns a prescaler or an internal loopback on or off. Two opcodes move data: one shifts counted bytes out on MOSI, and one clocks counted bytes in from MISO. Bytes clocked in come back on a valid/ready output stream.

The host drives chip select itself. It writes bit 3 of the pin bank low before a transfer and high after it. Length fields are 16 bits, sent low byte first, and hold the byte count minus one, so a single command moves up to 65536 bytes. When the output stream is not accepted, the bus clock stops between bytes, so no read data is ever lost.

The controller is a Moore state machine. Its states are:
- OPCODE: waiting for an opcode.
- LEN_LO and LEN_HI: collecting a 16-bit field.
- GPIO_VAL and GPIO_DIR: collecting the pin-bank bytes.
- WR_LOAD: taking the next byte to send.
- WR_SHIFT: sending that byte.
- RD_SHIFT: clocking a byte in.
- RD_PUSH: offering that byte on the output stream.

Its transitions are:
- OPCODE goes to LEN_LO on 0x86, 0x11 or 0x20.
- OPCODE goes to GPIO_VAL on 0x80.
- OPCODE stays in OPCODE for every other opcode.
- LEN_LO goes to LEN_HI.
- LEN_HI goes to OPCODE for a divisor, to WR_LOAD for a write, and to RD_SHIFT for a read.
- GPIO_VAL goes to GPIO_DIR, and GPIO_DIR goes to OPCODE.
- WR_LOAD goes to WR_SHIFT.
- WR_SHIFT goes back to WR_LOAD while bytes remain, and to OPCODE after the last byte.
- RD_SHIFT goes to RD_PUSH.
- RD_PUSH goes back to RD_SHIFT while bytes remain, and to OPCODE after the last byte.

Top module: `spi_cmd_engine`

## Requirements
- R1: Opcode 0x86 is followed by two bytes, low byte first. Together they form the 16-bit divisor value V.
- R2: The SCK half-period is (V+1)*P system clock cycles, so a full SCK period is 2*(V+1)*P cycles. P is 5 after reset or after opcode 0x8B, and 1 after opcode 0x8A. V is 0 after reset.
- R3: Opcode 0x80 is followed by a value byte and then a direction byte. pin_out takes the value and pin_oe takes the direction. Bit 3 is chip select, active low. Bit 0 carries SCK and bit 1 carries MOSI. Both registers are 0 after reset.
- R4: Opcode 0x11 is followed by a two-byte count-minus-one field (low byte first) and then that many data bytes. Each data byte goes out MSB first. SCK idles low. MOSI changes only on falling SCK edges and is stable at each rising edge.
- R5: Opcode 0x20 is followed by a two-byte count-minus-one field. The engine clocks in that many bytes, MSB first, sampling MISO on each rising SCK edge. MOSI is held at 1 throughout. The bytes appear on rsp_data in arrival order.
- R6: Opcode 0x84 turns internal loopback on and opcode 0x85 turns it off. Loopback is on after reset. While it is on, read bits are taken from MOSI instead of the miso pin, so a read returns 0xFF.
- R7: Once rsp_valid is high, it and rsp_data hold until rsp_ready accepts the byte. SCK makes no edge while a byte is waiting.
- R8: Any other opcode is consumed and has no effect on settings or pins. cmd_err is high for exactly one cycle, the cycle after that byte is accepted.
- R9: The count field uses its high byte: a count-minus-one of 0x0100 transfers exactly 257 bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_data | input | 8 | Command stream byte |
| cmd_valid | input | 1 | Command byte present |
| cmd_ready | output | 1 | Engine accepts a command byte |
| rsp_data | output | 8 | Byte read from the bus |
| rsp_valid | output | 1 | Read byte present |
| rsp_ready | input | 1 | Consumer accepts the read byte |
| pin_out | output | 8 | Pin bank level (bit0 SCK, bit1 MOSI, bit3 CS_n) |
| pin_oe | output | 8 | Pin bank output enables |
| miso | input | 1 | SPI data from the slave |
| cmd_err | output | 1 | One-cycle pulse on an unknown opcode |

## Verification
The bench measures the SCK period for three settings: the slowest reset prescaler, the fast base, and a divisor whose high byte is nonzero. A design that swapped the length bytes or dropped the prescaler would show a wrong period. Reads run with loopback on and then off, against a slave whose bytes change every eight bits. This exposes lost ordering or a loopback that fails to turn off. Holding rsp_ready low for a long stretch checks that exactly eight SCK rising edges occur and then nothing more. A design that kept clocking would overrun a byte. A 257-byte write checks that the high count byte is honoured. An unknown opcode must give exactly one cmd_err cycle and leave the clock rate unchanged.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam logic [7:0] OP_SET_DIV  = 8'h86;
    localparam logic [7:0] OP_FAST     = 8'h8A;
    localparam logic [7:0] OP_SLOW     = 8'h8B;
    localparam logic [7:0] OP_LOOP_ON  = 8'h84;
    localparam logic [7:0] OP_LOOP_OFF = 8'h85;
    localparam logic [7:0] OP_PINS     = 8'h80;
    localparam logic [7:0] OP_WRITE    = 8'h11;
    localparam logic [7:0] OP_READ     = 8'h20;

    typedef enum logic [3:0] {
        ST_OPCODE,
        ST_LEN_LO,
        ST_LEN_HI,
        ST_GPIO_VAL,
        ST_GPIO_DIR,
        ST_WR_LOAD,
        ST_WR_SHIFT,
        ST_RD_SHIFT,
        ST_RD_PUSH
    } eng_state_t;

    typedef enum logic [1:0] {
        USE_DIV,
        USE_WR,
        USE_RD
    } len_use_t;

endpackage

// File: rtl/sck_tick_gen.sv
module sck_tick_gen #(
    parameter int DIV_W = 16,
    parameter int PRE   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  logic             presc_on,
    output logic             tick
);
    localparam int EXT_W = DIV_W + $clog2(PRE + 1);

    logic [EXT_W-1:0] base;
    logic [EXT_W-1:0] lim;
    logic [EXT_W-1:0] cnt;

    always_comb begin
        base = EXT_W'(div) + EXT_W'(1);
        lim  = presc_on ? (base * EXT_W'(PRE)) - EXT_W'(1) : base - EXT_W'(1);
    end

    assign tick = en && (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!en || tick)
            cnt <= '0;
        else
            cnt <= cnt + EXT_W'(1);
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> cnt <= lim); // R2

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] tx_byte,
    input  logic         tick,
    input  logic         miso,
    output logic         busy,
    output logic         done,
    output logic         sck,
    output logic         mosi,
    output logic [W-1:0] rx_byte
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  tx_sr;
    logic [W-1:0]  rx_sr;
    logic [CW-1:0] bit_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr   <= '0;
            rx_sr   <= '0;
            bit_cnt <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
            sck     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                tx_sr   <= tx_byte;
                bit_cnt <= CW'(W - 1);
                busy    <= 1'b1;
                sck     <= 1'b0;
            end else if (busy && tick) begin
                if (!sck) begin
                    sck   <= 1'b1;
                    rx_sr <= {rx_sr[W-2:0], miso};
                end else begin
                    sck <= 1'b0;
                    if (bit_cnt == '0) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt - CW'(1);
                        tx_sr   <= {tx_sr[W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign mosi    = tx_sr[W-1];
    assign rx_byte = rx_sr;

    AST_SCK_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> busy); // R4
    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi)); // R4
    AST_DONE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(sck) && !sck)); // R4

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int LEN_W = 16,
    parameter int PRE   = 5,
    parameter int CS_BIT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] cmd_data,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    output logic [7:0] rsp_data,
    output logic       rsp_valid,
    input  logic       rsp_ready,
    output logic [7:0] pin_out,
    output logic [7:0] pin_oe,
    input  logic       miso,
    output logic       cmd_err
);
    eng_state_t state_q, state_d;
    len_use_t   use_q;

    logic [7:0]       lo_q;
    logic [LEN_W-1:0] len_q;
    logic [DIV_W-1:0] div_q;
    logic             presc_q;
    logic             loop_q;
    logic [7:0]       gval_q;
    logic [7:0]       gdir_q;
    logic             err_q;
    logic [7:0]       rsp_q;

    logic       accept;
    logic       known_op;
    logic       sh_start;
    logic [7:0] sh_tx;
    logic       sh_busy;
    logic       sh_done;
    logic       sh_sck;
    logic       sh_mosi;
    logic [7:0] sh_rx;
    logic       tick;
    logic       miso_eff;
    logic       len_last;

    sck_tick_gen #(.DIV_W(DIV_W), .PRE(PRE)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (sh_busy),
        .div      (div_q),
        .presc_on (presc_q),
        .tick     (tick)
    );

    assign miso_eff = loop_q ? sh_mosi : miso;

    spi_byte_shifter #(.W(8)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx_byte (sh_tx),
        .tick    (tick),
        .miso    (miso_eff),
        .busy    (sh_busy),
        .done    (sh_done),
        .sck     (sh_sck),
        .mosi    (sh_mosi),
        .rx_byte (sh_rx)
    );

    always_comb begin
        unique case (cmd_data)
            OP_SET_DIV, OP_FAST, OP_SLOW, OP_LOOP_ON, OP_LOOP_OFF,
            OP_PINS, OP_WRITE, OP_READ: known_op = 1'b1;
            default:                    known_op = 1'b0;
        endcase
    end

    assign len_last = (len_q == '0);

    // Output process: Moore handshakes plus shifter launch.
    always_comb begin
        cmd_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_OPCODE, ST_LEN_LO, ST_LEN_HI,
            ST_GPIO_VAL, ST_GPIO_DIR, ST_WR_LOAD: cmd_ready = 1'b1;
            ST_RD_PUSH:                           rsp_valid = 1'b1;
            default: ;
        endcase
        accept   = cmd_valid && cmd_ready;
        sh_start = (state_q == ST_WR_LOAD && accept)
                || (state_q == ST_LEN_HI && accept && use_q == USE_RD)
                || (state_q == ST_RD_PUSH && rsp_ready && !len_last);
        sh_tx    = (state_q == ST_WR_LOAD) ? cmd_data : 8'hFF;
    end

    // Next-state process.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPCODE: if (accept) begin
                if (cmd_data == OP_SET_DIV || cmd_data == OP_WRITE || cmd_data == OP_READ)
                    state_d = ST_LEN_LO;
                else if (cmd_data == OP_PINS)
                    state_d = ST_GPIO_VAL;
            end
            ST_LEN_LO:   if (accept) state_d = ST_LEN_HI;
            ST_LEN_HI: if (accept) begin
                unique case (use_q)
                    USE_WR:  state_d = ST_WR_LOAD;
                    USE_RD:  state_d = ST_RD_SHIFT;
                    default: state_d = ST_OPCODE;
                endcase
            end
            ST_GPIO_VAL: if (accept) state_d = ST_GPIO_DIR;
            ST_GPIO_DIR: if (accept) state_d = ST_OPCODE;
            ST_WR_LOAD:  if (accept) state_d = ST_WR_SHIFT;
            ST_WR_SHIFT: if (sh_done) state_d = len_last ? ST_OPCODE : ST_WR_LOAD;
            ST_RD_SHIFT: if (sh_done) state_d = ST_RD_PUSH;
            ST_RD_PUSH:  if (rsp_ready) state_d = len_last ? ST_OPCODE : ST_RD_SHIFT;
            default:     state_d = ST_OPCODE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPCODE;
        else        state_q <= state_d;
    end

    // Settings, counters and data.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            use_q   <= USE_DIV;
            lo_q    <= '0;
            len_q   <= '0;
            div_q   <= '0;
            presc_q <= 1'b1;
            loop_q  <= 1'b1;
            gval_q  <= '0;
            gdir_q  <= '0;
            err_q   <= 1'b0;
            rsp_q   <= '0;
        end else begin
            err_q <= 1'b0;
            unique case (state_q)
                ST_OPCODE: if (accept) begin
                    unique case (cmd_data)
                        OP_SET_DIV:  use_q   <= USE_DIV;
                        OP_WRITE:    use_q   <= USE_WR;
                        OP_READ:     use_q   <= USE_RD;
                        OP_FAST:     presc_q <= 1'b0;
                        OP_SLOW:     presc_q <= 1'b1;
                        OP_LOOP_ON:  loop_q  <= 1'b1;
                        OP_LOOP_OFF: loop_q  <= 1'b0;
                        default:     err_q   <= !known_op;
                    endcase
                end
                ST_LEN_LO: if (accept) lo_q <= cmd_data;
                ST_LEN_HI: if (accept) begin
                    if (use_q == USE_DIV) div_q <= DIV_W'({cmd_data, lo_q});
                    else                  len_q <= LEN_W'({cmd_data, lo_q});
                end
                ST_GPIO_VAL: if (accept) gval_q <= cmd_data;
                ST_GPIO_DIR: if (accept) gdir_q <= cmd_data;
                ST_WR_SHIFT: if (sh_done && !len_last) len_q <= len_q - LEN_W'(1);
                ST_RD_SHIFT: if (sh_done) rsp_q <= sh_rx;
                ST_RD_PUSH:  if (rsp_ready && !len_last) len_q <= len_q - LEN_W'(1);
                default: ;
            endcase
        end
    end

    assign rsp_data = rsp_q;
    assign cmd_err  = err_q;
    assign pin_oe   = gdir_q;

    always_comb begin
        pin_out    = gval_q;
        pin_out[0] = gval_q[0] | sh_sck;
        pin_out[1] = sh_busy ? sh_mosi : gval_q[1];
    end

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R7
    AST_NO_SCK_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !sh_sck); // R7
    AST_ERR_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(cmd_valid && cmd_ready)); // R8
    AST_READY_IDLE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !sh_busy); // R4
    AST_CS_STEADY_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_busy && $past(sh_busy)) |-> $stable(pin_out[CS_BIT])); // R3

endmodule

// File: tb/tb_spi_cmd_engine.sv
module tb_spi_cmd_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cmd_data = '0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [7:0] rsp_data;
    logic       rsp_valid;
    logic       rsp_ready = 1'b0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic       miso;
    logic       cmd_err;

    always #4 clk = ~clk;

    spi_cmd_engine dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_data(cmd_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .rsp_data(rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .pin_out(pin_out), .pin_oe(pin_oe), .miso(miso), .cmd_err(cmd_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // slave model: shifts MSB first on falling SCK, next byte = previous + 0x11
    logic [7:0] slv_val = 8'h00;
    logic [7:0] slv_sr = 8'h00;
    int         slv_bc = 0;
    assign miso = slv_sr[7];
    always @(negedge pin_out[0]) if (!pin_out[3]) begin
        if (slv_bc == 7) begin
            slv_bc  <= 0;
            slv_val <= slv_val + 8'h11;
            slv_sr  <= slv_val + 8'h11;
        end else begin
            slv_bc <= slv_bc + 1;
            slv_sr <= {slv_sr[6:0], 1'b0};
        end
    end

    // MOSI capture on rising SCK
    logic [7:0] cap_sr = '0;
    int         cap_bc = 0;
    int         cap_n = 0;
    logic [7:0] cap_log [0:511];
    always @(posedge pin_out[0]) if (!pin_out[3]) begin
        if (cap_bc == 7) begin
            cap_log[cap_n] <= {cap_sr[6:0], pin_out[1]};
            cap_n  <= cap_n + 1;
            cap_bc <= 0;
        end else begin
            cap_bc <= cap_bc + 1;
        end
        cap_sr <= {cap_sr[6:0], pin_out[1]};
    end

    // negedge monitor: response collection, SCK period, error pulses
    int         stall_mode = 0;
    int         rsp_n = 0;
    logic [7:0] rsp_log [0:15];
    logic       prev_sck = 1'b0;
    int         last_rise = -1;
    int         per_meas = 0;
    int         rise_cnt = 0;
    int         err_cnt = 0;
    int         sck_viol = 0;
    always @(negedge clk) begin
        logic nxt;
        cyc <= cyc + 1;
        case (stall_mode)
            1:       nxt = (cyc % 4 == 0);
            2:       nxt = 1'b0;
            default: nxt = 1'b1;
        endcase
        rsp_ready <= nxt;
        if (rsp_valid && nxt) begin
            rsp_log[rsp_n] <= rsp_data;
            rsp_n <= rsp_n + 1;
        end
        if (rsp_valid && pin_out[0]) sck_viol <= sck_viol + 1;
        if (pin_out[0] && !prev_sck) begin
            if (last_rise >= 0) per_meas <= cyc - last_rise;
            last_rise <= cyc;
            rise_cnt  <= rise_cnt + 1;
        end
        prev_sck <= pin_out[0];
        if (cmd_err) err_cnt <= err_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        cmd_data  = b;
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pins(input logic [7:0] v, input logic [7:0] d);
        send(8'h80); send(v); send(d);
    endtask

    task automatic set_div(input logic [15:0] v);
        send(8'h86); send(v[7:0]); send(v[15:8]);
    endtask

    // one-byte write, returns measured SCK period
    task automatic write_one(input logic [7:0] b, output int per);
        cap_n = 0; cap_bc = 0; last_rise = -1; per_meas = 0;
        pins(8'h00, 8'h0b);
        send(8'h11); send(8'h00); send(8'h00); send(b);
        pins(8'h08, 8'h0b);
        per = per_meas;
    endtask

    task automatic test_reset;
        chk(cmd_ready == 1'b1, "R3 reset ready", int'(cmd_ready), 1);
        chk(rsp_valid == 1'b0, "R3 reset rsp_valid", int'(rsp_valid), 0);
        chk(pin_out == 8'h00, "R3 reset pin_out", int'(pin_out), 0);
        chk(pin_oe == 8'h00, "R3 reset pin_oe", int'(pin_oe), 0);
        chk(cmd_err == 1'b0, "R8 reset err", int'(cmd_err), 0);
    endtask

    task automatic test_pins;
        pins(8'h08, 8'h0b);
        idle(2);
        chk(pin_out == 8'h08, "R3 value byte", int'(pin_out), 8'h08);
        chk(pin_oe == 8'h0b, "R3 direction byte", int'(pin_oe), 8'h0b);
    endtask

    task automatic test_slow_prescale;
        int per;
        write_one(8'h96, per);  // reset: V=0, P=5
        chk(per == 10, "R2 reset prescaled period", per, 10);
        chk(cap_n == 1 && cap_log[0] == 8'h96, "R4 slow byte", int'(cap_log[0]), 8'h96);
    endtask

    task automatic test_fast_write;
        int per;
        send(8'h8A);
        set_div(16'd2);
        write_one(8'hA5, per);
        chk(per == 6, "R2 fast period V=2", per, 6);
        chk(cap_n == 1 && cap_log[0] == 8'hA5, "R4 write MSB first", int'(cap_log[0]), 8'hA5);
        chk(pin_out[0] == 1'b0, "R4 SCK idles low", int'(pin_out[0]), 0);
        send(8'h8B);
        write_one(8'h3C, per);
        chk(per == 30, "R2 prescaler back on", per, 30);
        send(8'h8A);
    endtask

    task automatic test_div_order;
        int per;
        set_div(16'h0103);
        write_one(8'h5A, per);
        chk(per == 2 * 16'h0104, "R1 divisor low then high", per, 2 * 16'h0104);
    endtask

    task automatic test_long_write;
        int bad = 0;
        set_div(16'd0);
        cap_n = 0; cap_bc = 0;
        pins(8'h00, 8'h0b);
        send(8'h11); send(8'h00); send(8'h01);
        for (int i = 0; i < 257; i++) send(8'(i * 7 + 1));
        pins(8'h08, 8'h0b);
        idle(4);
        chk(cap_n == 257, "R9 257 bytes written", cap_n, 257);
        for (int i = 0; i < 257; i++) if (cap_log[i] != 8'(i * 7 + 1)) bad++;
        chk(bad == 0, "R4 multi-byte order", bad, 0);
    endtask

    task automatic do_read(input int n, input logic [7:0] first, input int mode,
                           input bit loop_on, input string req);
        int bad = 0;
        int t = 0;
        slv_val = first; slv_sr = first; slv_bc = 0;
        rsp_n = 0; sck_viol = 0;
        stall_mode = mode;
        pins(8'h00, 8'h0b);
        send(8'h20); send(8'(n - 1)); send(8'h00);
        while (rsp_n < n && t < 20000) begin @(negedge clk); t++; end
        pins(8'h08, 8'h0b);
        stall_mode = 0;
        chk(rsp_n == n, {req, " byte count"}, rsp_n, n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] e;
            e = loop_on ? 8'hFF : 8'(first + 8'(i * 8'h11));
            if (rsp_log[i] != e) begin
                bad++;
                $display("FAIL %s byte %0d actual=0x%0h expected=0x%0h", req, i, rsp_log[i], e);
            end
        end
        chk(bad == 0, {req, " data"}, bad, 0);
    endtask

    task automatic test_reads;
        do_read(1, 8'h5A, 0, 1'b1, "R6 loopback on by reset");
        send(8'h85);
        do_read(3, 8'h5A, 0, 1'b0, "R5 read order");
        send(8'h84);
        do_read(2, 8'h21, 0, 1'b1, "R6 loopback re-enabled");
        send(8'h85);
        do_read(4, 8'h80, 1, 1'b0, "R7 intermittent ready");
        chk(sck_viol == 0, "R7 no SCK while pending", sck_viol, 0);
    endtask

    task automatic test_backpressure;
        int t = 0;
        slv_val = 8'hC3; slv_sr = 8'hC3; slv_bc = 0;
        rsp_n = 0;
        stall_mode = 2;
        pins(8'h00, 8'h0b);
        rise_cnt = 0;
        send(8'h20); send(8'h01); send(8'h00);
        idle(300);
        chk(rise_cnt == 8, "R7 SCK stops while held", rise_cnt, 8);
        chk(rsp_valid == 1'b1, "R7 valid held", int'(rsp_valid), 1);
        chk(rsp_data == 8'hC3, "R7 data held", int'(rsp_data), 8'hC3);
        stall_mode = 0;
        while (rsp_n < 2 && t < 2000) begin @(negedge clk); t++; end
        chk(rsp_n == 2 && rsp_log[0] == 8'hC3 && rsp_log[1] == 8'hD4,
            "R5 bytes after release", int'(rsp_log[1]), 8'hD4);
        chk(rise_cnt == 16, "R7 total edges", rise_cnt, 16);
        pins(8'h08, 8'h0b);
    endtask

    task automatic test_unknown;
        int per;
        set_div(16'd3);
        err_cnt = 0;
        send(8'hA5);
        idle(3);
        chk(err_cnt == 1, "R8 one-cycle error pulse", err_cnt, 1);
        chk(pin_out == 8'h08 && pin_oe == 8'h0b, "R8 pins untouched", int'(pin_out), 8'h08);
        write_one(8'h0F, per);
        chk(per == 8, "R8 divisor untouched", per, 8);
        chk(cap_log[0] == 8'h0F, "R8 next command works", int'(cap_log[0]), 8'h0F);
    endtask

    initial begin : watchdog
        while (cyc < 150000) @(negedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle(3);
        test_reset;
        rst_n = 1'b1;
        idle(2);
        test_reset;
        test_pins;
        test_slow_prescale;
        test_fast_write;
        test_div_order;
        test_long_write;
        test_reads;
        test_backpressure;
        test_unknown;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule